// File: doc/BRIEF.md
# Bus Timeout and Error Monitor

This block sits between one bus master and a simple ready-handshake bus. It watches every beat the master presents. An access whose address falls outside a programmable legal window is refused in its first cycle, and the slave never sees it. An access whose slave stays silent for a programmable number of cycles is cut off. In both cases the master gets ready together with an error flag, so it never hangs on a faulty or missing slave.

Single accesses and burst beats are checked the same way. Every failing beat earns its own error response, even when several beats of one burst time out in a row.

The first error is recorded in sticky status registers: its kind, whether it was a burst beat, and its address. The record is frozen until software clears it. A level interrupt reports a held record when notification is enabled. A five-word register port holds the enables, the timeout threshold, the window bounds and the status.

Top module: `bus_err_monitor`

## Requirements
- R1: With monitoring enabled, a beat whose address is below the base register or above the limit register is answered in its first cycle with `m_ready`=1 and `m_err`=1, and `s_req` stays 0 for that beat. Both bounds are inclusive legal addresses.
- R2: With monitoring enabled, a legal beat that has no `s_ready` before cycle THR (the first cycle of the beat counts as cycle 0) is ended in cycle THR with `m_ready`=1 and `m_err`=1. An `s_ready` that arrives in that same cycle is overridden by the error.
- R3: The wait count restarts for every beat. In a burst (`m_burst`=1), consecutive failing beats each receive their own timeout termination after THR cycles, and a later good beat completes normally. N failing beats give N error responses.
- R4: With the enable bit (control bit 0) clear, no error is raised: `m_ready` follows `s_ready`, `m_err` stays 0, and status stays unchanged.
- R5: The first error sets status register 3. Bit 0 marks an illegal-address error, bit 1 a timeout, and bit 2 a burst beat. The beat address is stored in register 4.
- R6: While any status kind bit is set, later errors leave registers 3 and 4 unchanged.
- R7: Writing register 3 with a 1 in a set kind bit clears the record. If an error occurs in the same cycle as that clear, the new error is captured.
- R8: `irq` is high exactly while a status kind bit is set and the notify bit (control bit 1) is 1.
- R9: After reset, control reads with enable and notify at 0 and threshold 16 in bits 15:8. The base is 0, the limit is all ones, status is 0, and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| m_req | input | 1 | Master beat request, held until `m_ready` |
| m_addr | input | AW | Beat address |
| m_burst | input | 1 | Beat belongs to a burst |
| m_ready | output | 1 | Beat done toward the master |
| m_err | output | 1 | Error response, valid with `m_ready` |
| s_req | output | 1 | Request forwarded to the slave |
| s_ready | input | 1 | Slave completion |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select: 0 control, 1 base, 2 limit, 3 status, 4 error address |
| reg_wdata | input | AW | Register write data |
| reg_rdata | output | AW | Register read data (combinational) |
| irq | output | 1 | Level error interrupt |

## Verification
A wait counter that fails to restart at a beat boundary shows up directly at the ports. The next burst beat is then cut short or left hanging, and its error response is off by cycles as soon as that beat ends. A status record that is not locked, or that is cleared wrongly, shows up at the next read of registers 3 and 4, which would hold the address of the wrong beat. It also shows as `irq` changing level in the very cycle after the error or the clear.

// File: rtl/bus_err_monitor.sv
module bus_err_monitor #(
  parameter int AW = 16,
  parameter int TW = 8,
  parameter logic [TW-1:0] THR_RST = 8'd16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          m_req,
  input  logic [AW-1:0] m_addr,
  input  logic          m_burst,
  output logic          m_ready,
  output logic          m_err,
  output logic          s_req,
  input  logic          s_ready,
  input  logic          reg_wr,
  input  logic [2:0]    reg_addr,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  output logic          irq
);
  localparam int PAD = AW - TW - 2;

  logic          en, nen;
  logic [TW-1:0] thr, cnt;
  logic [AW-1:0] base, limit, st_addr;
  logic          st_ill, st_tmo, st_burst;
  logic          bad, tmo, err_ev, locked, clr;

  assign bad    = en & m_req & ((m_addr < base) | (m_addr > limit));
  assign tmo    = en & m_req & ~bad & (cnt == thr);
  assign err_ev = bad | tmo;
  assign s_req  = m_req & ~bad;
  assign m_err  = err_ev;
  assign m_ready = m_req & (err_ev | s_ready);
  assign locked = st_ill | st_tmo;
  assign clr    = reg_wr & (reg_addr == 3'd3) & |(reg_wdata[1:0] & {st_tmo, st_ill});
  assign irq    = nen & locked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt <= '0;
    else if (!en || !m_req || m_ready) cnt <= '0;
    else                               cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en    <= 1'b0;
      nen   <= 1'b0;
      thr   <= THR_RST;
      base  <= '0;
      limit <= '1;
    end else if (reg_wr) begin
      case (reg_addr)
        3'd0: begin
          en  <= reg_wdata[0];
          nen <= reg_wdata[1];
          thr <= reg_wdata[AW-1 -: TW];
        end
        3'd1: base  <= reg_wdata;
        3'd2: limit <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_ill   <= 1'b0;
      st_tmo   <= 1'b0;
      st_burst <= 1'b0;
      st_addr  <= '0;
    end else if (err_ev && (!locked || clr)) begin
      st_ill   <= bad;
      st_tmo   <= tmo;
      st_burst <= m_burst;
      st_addr  <= m_addr;
    end else if (clr) begin
      st_ill   <= 1'b0;
      st_tmo   <= 1'b0;
      st_burst <= 1'b0;
    end
  end

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = {thr, {PAD{1'b0}}, nen, en};
      3'd1:    reg_rdata = base;
      3'd2:    reg_rdata = limit;
      3'd3:    reg_rdata = {{(AW-3){1'b0}}, st_burst, st_tmo, st_ill};
      3'd4:    reg_rdata = st_addr;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/bus_err_monitor_chk.sv
module bus_err_monitor_chk #(
  parameter int AW = 16,
  parameter int TW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          nen,
  input logic [TW-1:0] thr,
  input logic          m_req,
  input logic          m_ready,
  input logic          m_err,
  input logic          s_req,
  input logic          bad,
  input logic          locked,
  input logic          clr,
  input logic [AW-1:0] st_addr,
  input logic          irq
);
  logic [TW-1:0] wcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        wcnt <= '0;
    else if (!en || !m_req || m_ready) wcnt <= '0;
    else                               wcnt <= wcnt + 1'b1;
  end

  // R1
  illegal_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad |-> (m_err && m_ready && !s_req));

  // R2
  wait_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && m_req && !m_ready) |-> (wcnt < thr));

  // R3
  err_with_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_err |-> m_ready);

  // R4
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !m_err);

  // R6
  record_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !clr) |=> $stable(st_addr));

  // R8
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nen |-> !irq);
endmodule

bind bus_err_monitor bus_err_monitor_chk #(.AW(AW), .TW(TW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .nen(nen), .thr(thr),
  .m_req(m_req), .m_ready(m_ready), .m_err(m_err), .s_req(s_req),
  .bad(bad), .locked(locked), .clr(clr), .st_addr(st_addr), .irq(irq)
);

// File: tb/test_bus_err_monitor.sv
module test_bus_err_monitor;
  logic        clk = 0, rst_n = 0;
  logic        m_req = 0, m_burst = 0;
  logic [15:0] m_addr = '0;
  logic        m_ready, m_err, s_req, s_ready, irq;
  logic        reg_wr = 0;
  logic [2:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  int          errors = 0, checks = 0;
  int          sdelay = 0, scnt = 0, lat = 0;
  bit          sreq_seen = 0;
  bit          q_err[$];
  int          q_lat[$];
  string       q_tag[$];

  always #10 clk = ~clk;

  bus_err_monitor i_bus_err_monitor (
    .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_addr(m_addr), .m_burst(m_burst),
    .m_ready(m_ready), .m_err(m_err), .s_req(s_req), .s_ready(s_ready),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  assign s_ready = s_req && (scnt == sdelay);

  always @(posedge clk) begin
    if (!s_req || m_ready) scnt <= 0;
    else                   scnt <= scnt + 1;
  end

  always @(negedge clk) begin
    if (s_req) sreq_seen = 1;
    if (m_req) begin
      if (m_ready) begin
        checks++;
        if (q_err.size() == 0) begin
          errors++;
          $display("FAIL scoreboard: unexpected completion err=%0b lat=%0d, expected none", m_err, lat);
        end else begin
          automatic bit    ee = q_err.pop_front();
          automatic int    el = q_lat.pop_front();
          automatic string tg = q_tag.pop_front();
          if (m_err !== ee || lat != el) begin
            errors++;
            $display("FAIL %s: err=%0b lat=%0d, expected err=%0b lat=%0d", tg, m_err, lat, ee, el);
          end
        end
        lat = 0;
      end else lat++;
    end
  end

  task automatic check(input string tg, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tg, got, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [15:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 0;
  endtask

  task automatic rreg(input logic [2:0] a, input logic [15:0] exp, input string tg);
    reg_addr = a;
    @(negedge clk);
    check(tg, reg_rdata, exp);
    @(posedge clk); #1;
  endtask

  task automatic beat(input logic [15:0] a, input logic b, input int d,
                      input bit ee, input int el, input string tg);
    q_err.push_back(ee); q_lat.push_back(el); q_tag.push_back(tg);
    sreq_seen = 0; m_req = 1; m_addr = a; m_burst = b; sdelay = d;
    do @(negedge clk); while (!m_ready);
    @(posedge clk); #1;
  endtask

  task automatic idle();
    m_req = 0; m_burst = 0;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check("R9 irq", {15'b0, irq}, 16'h0);
    rreg(3'd0, 16'h1000, "R9 ctrl");
    rreg(3'd2, 16'hFFFF, "R9 limit");
    rreg(3'd3, 16'h0000, "R9 status");

    wreg(3'd1, 16'h0100);
    wreg(3'd2, 16'h01FF);
    beat(16'h0300, 0, 2, 0, 2, "R4 disabled illegal");
    idle();
    beat(16'h0150, 0, 20, 0, 20, "R4 disabled slow");
    idle();
    rreg(3'd3, 16'h0000, "R4 status untouched");

    wreg(3'd0, 16'h0401);
    beat(16'h0150, 0, 1, 0, 1, "R2 good beat");
    idle();
    beat(16'h0050, 0, 0, 1, 0, "R1 below base");
    check("R1 slave not requested", {15'b0, sreq_seen}, 16'h0);
    idle();
    rreg(3'd3, 16'h0001, "R5 illegal kind");
    rreg(3'd4, 16'h0050, "R5 address");
    check("R8 irq masked", {15'b0, irq}, 16'h0);

    beat(16'h0160, 0, 10, 1, 4, "R2 timeout");
    idle();
    rreg(3'd3, 16'h0001, "R6 kind kept");
    rreg(3'd4, 16'h0050, "R6 address kept");

    wreg(3'd0, 16'h0403);
    @(negedge clk);
    check("R8 irq raised", {15'b0, irq}, 16'h1);
    @(posedge clk); #1;
    wreg(3'd3, 16'h0001);
    rreg(3'd3, 16'h0000, "R7 cleared");
    check("R8 irq dropped", {15'b0, irq}, 16'h0);

    beat(16'h0180, 1, 10, 1, 4, "R3 burst beat0 timeout");
    beat(16'h0184, 1, 10, 1, 4, "R3 burst beat1 timeout");
    beat(16'h0188, 1, 2, 0, 2, "R3 burst beat2 ok");
    idle();
    rreg(3'd3, 16'h0006, "R5 burst timeout kind");
    rreg(3'd4, 16'h0180, "R5 R6 first beat address");

    beat(16'h0170, 0, 4, 1, 4, "R2 ready at threshold loses");
    idle();
    beat(16'h01FF, 0, 0, 0, 0, "R1 limit is legal");
    idle();
    beat(16'h0100, 0, 0, 0, 0, "R1 base is legal");
    idle();
    beat(16'h00FF, 0, 0, 1, 0, "R1 just below base");
    idle();
    rreg(3'd4, 16'h0180, "R6 still first");

    q_err.push_back(1); q_lat.push_back(0); q_tag.push_back("R7 error with clear");
    m_req = 1; m_addr = 16'h02AA; m_burst = 0;
    reg_wr = 1; reg_addr = 3'd3; reg_wdata = 16'h0002;
    @(posedge clk); #1;
    reg_wr = 0; m_req = 0;
    rreg(3'd3, 16'h0001, "R7 new error captured");
    rreg(3'd4, 16'h02AA, "R7 new address captured");
    check("R8 irq after recapture", {15'b0, irq}, 16'h1);

    repeat (2) @(posedge clk);
    if (q_err.size() != 0) begin
      checks++; errors++;
      $display("FAIL R3 scoreboard: %0d responses missing, expected 0", q_err.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule